// File: doc/BRIEF.md
# Multicycle 8-bit Register-Bus Processor Core

This block is a small 8-bit processor. Every instruction is one byte, and a step sequencer runs it over several clock cycles with no overlap between instructions. The core holds four general registers, an instruction pointer and an instruction register. It also has a memory address register and a memory data register. The arithmetic side has separate operand and result registers for the adder and for the AND unit, plus an inverter register, an immediate register and three condition flags.

The core drives a 256-entry by 8-bit synchronous memory through an address, a write strobe and write data, and it takes read data back one cycle after the address. An 8-bit user input port can be copied into a register. A registered 8-bit output port holds the last value sent out. The core is used by loading a program image into the memory while reset is held, then releasing reset. Fetching then starts at address 0x00.

Top module: `octet_core`

## Requirements
- R1: An instruction byte decodes as opcode in bits [7:5], first register index in [4:3], mode in [2] and second field in [1:0]. Opcodes are 0 jump, 1 add, 2 and, 3 move/invert, 4 load, 5 store, 6 input, 7 output. Instructions run in address order, and the instruction pointer wraps from 0xFF to 0x00.
- R2: While reset is high, all registers, the flags and the output port clear and no memory write is issued. After release, the first fetch reads address 0x00.
- R3: Jump (opcode 0) loads the instruction pointer from the register named in [4:3] only when its mask in [2:0] shares a set bit with the flags. Bit 2 is negative, bit 1 zero and bit 0 positive. Byte 0x00 therefore never jumps.
- R4: Add (opcode 1) writes first-register plus second operand, modulo 256, into R0, whichever register is named first.
- R5: And (opcode 2) writes the bitwise AND of the first register and the second operand into R0, whichever register is named first.
- R6: With mode 1, add and and take the second operand as bits [1:0] zero-extended to 8 bits. With mode 0, they take it from the register indexed by [1:0].
- R7: Move (opcode 3) copies the register named in [1:0] into the register named in [4:3]. With mode 1 it writes the bitwise inverse instead.
- R8: Load (opcode 4) writes memory at the address held in the [1:0] register into the [4:3] register. Store (opcode 5) writes the [4:3] register to memory at the address held in the [1:0] register, with a write strobe one cycle long.
- R9: Input (opcode 6) copies the user input into the [4:3] register. Output (opcode 7) copies the [4:3] register to the output port, and no other instruction changes that port.
- R10: Every register write sets exactly one flag from the written value, read as two's complement. Jump, store and output leave the flags unchanged. Flags are all clear after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Registered memory address |
| mem_we | output | 1 | Registered memory write strobe |
| mem_wdata | output | 8 | Registered memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| usr_in | input | 8 | User input value |
| usr_out | output | 8 | Registered output port |

## Verification
Registers and flags are visible only through the output port and through store traffic. A wrong register value therefore shows up at the next output or store instruction that uses it, which is one or more instruction times later (seven to ten cycles each). A wrong flag shows up only as a jump taken or skipped. Short programs are used so that each such fault changes which value reaches the output port. A fault in the fetch sequence or in the pointer shows up as the wrong instruction running, or as an output that changes too early or too late across a full wrap of the address space.

// File: rtl/octet_pkg.sv
package octet_pkg;

  typedef enum logic [2:0] {
    OP_JMP = 3'd0,
    OP_ADD = 3'd1,
    OP_AND = 3'd2,
    OP_MOV = 3'd3,
    OP_LD  = 3'd4,
    OP_ST  = 3'd5,
    OP_IN  = 3'd6,
    OP_OUT = 3'd7
  } opc_e;

  typedef enum logic [2:0] {
    PH_FADDR,
    PH_FREAD,
    PH_FDATA,
    PH_FIR,
    PH_INC,
    PH_IPWR,
    PH_EXEC
  } phase_e;

  typedef enum logic [2:0] {
    CC_IDLE,
    CC_LDADD,
    CC_LDAND,
    CC_ADD,
    CC_AND,
    CC_NOT
  } calc_e;

endpackage

// File: rtl/octet_regs.sv
module octet_regs #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] sel_a,
  input  logic [RW-1:0] sel_b,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic [DW-1:0] wr_val,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);

  logic [DW-1:0] rf [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        rf[g] <= '0;
      end else if (wr_en && wr_idx == RW'(g)) begin
        rf[g] <= wr_val;
      end
    end
  end

  assign rd_a = rf[sel_a];
  assign rd_b = rf[sel_b];

endmodule

// File: rtl/octet_calc.sv
module octet_calc
  import octet_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  calc_e         cmd,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [IW-1:0] imm,
  input  logic          use_imm,
  output logic [DW-1:0] sum_q,
  output logic [DW-1:0] and_q,
  output logic [DW-1:0] not_q
);

  logic [DW-1:0] add_in;
  logic [DW-1:0] and_in;
  logic [DW-1:0] imm_q;
  logic [DW-1:0] operand;

  assign operand = use_imm ? imm_q : opb;

  always_ff @(posedge clk) begin
    if (rst) begin
      add_in <= '0;
      and_in <= '0;
      imm_q  <= '0;
      sum_q  <= '0;
      and_q  <= '0;
      not_q  <= '0;
    end else begin
      case (cmd)
        CC_LDADD: begin
          add_in <= opa;
          imm_q  <= DW'(imm);
        end
        CC_LDAND: begin
          and_in <= opa;
          imm_q  <= DW'(imm);
        end
        CC_ADD:  sum_q <= add_in + operand;
        CC_AND:  and_q <= and_in & operand;
        CC_NOT:  not_q <= ~opb;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/octet_ctrl.sv
module octet_ctrl
  import octet_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 8,
  localparam int RW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] usr_in,
  input  logic [DW-1:0] rd_a,
  input  logic [DW-1:0] rd_b,
  input  logic [DW-1:0] sum_q,
  input  logic [DW-1:0] and_q,
  input  logic [DW-1:0] not_q,
  output logic [RW-1:0] sel_a,
  output logic [RW-1:0] sel_b,
  output logic          wr_en,
  output logic [RW-1:0] wr_idx,
  output logic [DW-1:0] wr_val,
  output calc_e         calc_cmd,
  output logic [RW-1:0] imm,
  output logic          use_imm,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] usr_out,
  output logic [2:0]    cc,
  output logic [2:0]    op_o
);

  phase_e        ph;
  logic [1:0]    stp;
  logic [7:0]    ir;
  logic [AW-1:0] ip;
  logic [AW-1:0] ipn;
  logic [AW-1:0] mar;
  logic [DW-1:0] mdr;
  logic [2:0]    cc_q;
  logic          we_q;
  logic [DW-1:0] out_q;
  logic          last;
  opc_e          op;
  logic          md;

  function automatic logic [2:0] cc_of(input logic [DW-1:0] v);
    if (v[DW-1])       return 3'b100;
    else if (v == '0)  return 3'b010;
    else               return 3'b001;
  endfunction

  assign op      = opc_e'(ir[7:5]);
  assign md      = ir[2];
  assign sel_a   = ir[4:3];
  assign sel_b   = ir[1:0];
  assign imm     = ir[1:0];
  assign use_imm = md;

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = sel_a;
    wr_val   = rd_b;
    calc_cmd = CC_IDLE;
    last     = 1'b0;
    if (ph == PH_EXEC) begin
      case (op)
        OP_ADD, OP_AND: begin
          if (stp == 2'd0) begin
            calc_cmd = (op == OP_ADD) ? CC_LDADD : CC_LDAND;
          end else if (stp == 2'd1) begin
            calc_cmd = (op == OP_ADD) ? CC_ADD : CC_AND;
          end else begin
            wr_en  = 1'b1;
            wr_idx = '0;
            wr_val = (op == OP_ADD) ? sum_q : and_q;
            last   = 1'b1;
          end
        end
        OP_MOV: begin
          if (!md) begin
            wr_en = 1'b1;
            last  = 1'b1;
          end else if (stp == 2'd0) begin
            calc_cmd = CC_NOT;
          end else begin
            wr_en  = 1'b1;
            wr_val = not_q;
            last   = 1'b1;
          end
        end
        OP_LD: begin
          if (stp == 2'd3) begin
            wr_en  = 1'b1;
            wr_val = mdr;
            last   = 1'b1;
          end
        end
        OP_ST: last = (stp == 2'd2);
        OP_IN: begin
          wr_en  = 1'b1;
          wr_val = usr_in;
          last   = 1'b1;
        end
        default: last = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_FADDR;
      stp   <= '0;
      ir    <= '0;
      ip    <= '0;
      ipn   <= '0;
      mar   <= '0;
      mdr   <= '0;
      cc_q  <= '0;
      we_q  <= 1'b0;
      out_q <= '0;
    end else begin
      case (ph)
        PH_FADDR: begin
          mar <= ip;
          ph  <= PH_FREAD;
        end
        PH_FREAD: ph <= PH_FDATA;
        PH_FDATA: begin
          mdr <= mem_rdata;
          ph  <= PH_FIR;
        end
        PH_FIR: begin
          ir <= mdr[7:0];
          ph <= PH_INC;
        end
        PH_INC: begin
          ipn <= ip + AW'(1);
          ph  <= PH_IPWR;
        end
        PH_IPWR: begin
          ip  <= ipn;
          stp <= '0;
          ph  <= PH_EXEC;
        end
        default: begin
          stp <= stp + 2'd1;
          if (last) ph <= PH_FADDR;
          case (op)
            OP_JMP: if ((ir[2:0] & cc_q) != 3'b000) ip <= AW'(rd_a);
            OP_LD: begin
              if (stp == 2'd0) mar <= AW'(rd_b);
              if (stp == 2'd2) mdr <= mem_rdata;
            end
            OP_ST: begin
              if (stp == 2'd0) mdr <= rd_a;
              if (stp == 2'd1) begin
                mar  <= AW'(rd_b);
                we_q <= 1'b1;
              end
              if (stp == 2'd2) we_q <= 1'b0;
            end
            OP_OUT: out_q <= rd_a;
            default: ;
          endcase
        end
      endcase
      if (wr_en) cc_q <= cc_of(wr_val);
    end
  end

  assign mem_addr  = mar;
  assign mem_we    = we_q;
  assign mem_wdata = mdr;
  assign usr_out   = out_q;
  assign cc        = cc_q;
  assign op_o      = ir[7:5];

endmodule

// File: rtl/octet_core.sv
module octet_core
  import octet_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] usr_in,
  output logic [DW-1:0] usr_out
);

  logic [RW-1:0] sel_a, sel_b, wr_idx, imm;
  logic          wr_en, use_imm;
  logic [DW-1:0] wr_val, rd_a, rd_b;
  logic [DW-1:0] sum_q, and_q, not_q;
  calc_e         calc_cmd;
  logic [2:0]    cc_w;
  logic [2:0]    op_w;

  octet_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk(clk), .rst(rst),
    .sel_a(sel_a), .sel_b(sel_b),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .rd_a(rd_a), .rd_b(rd_b)
  );

  octet_calc #(.DW(DW), .IW(RW)) u_calc (
    .clk(clk), .rst(rst), .cmd(calc_cmd),
    .opa(rd_a), .opb(rd_b), .imm(imm), .use_imm(use_imm),
    .sum_q(sum_q), .and_q(and_q), .not_q(not_q)
  );

  octet_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst),
    .mem_rdata(mem_rdata), .usr_in(usr_in),
    .rd_a(rd_a), .rd_b(rd_b),
    .sum_q(sum_q), .and_q(and_q), .not_q(not_q),
    .sel_a(sel_a), .sel_b(sel_b),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .calc_cmd(calc_cmd), .imm(imm), .use_imm(use_imm),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .usr_out(usr_out), .cc(cc_w), .op_o(op_w)
  );

endmodule

// File: rtl/octet_chk.sv
module octet_chk
  import octet_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] usr_out,
  input logic [2:0]    cc,
  input logic [2:0]    op
);

  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  AST_RESET_IDLE: assert property (@(posedge clk)
    (seen && $past(rst)) |-> (usr_out == '0 && !mem_we && mem_addr == '0)); // R2

  AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cc)); // R10

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R8

  AST_WE_ON_STORE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> op == OP_ST); // R8

  AST_OUT_ONLY_OUT: assert property (@(posedge clk) disable iff (rst)
    !$stable(usr_out) |-> op == OP_OUT); // R9

endmodule

bind octet_core octet_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_we(mem_we), .mem_addr(mem_addr),
  .usr_out(usr_out), .cc(cc_w), .op(op_w)
);

// File: tb/sim_octet_core.sv
module sim_octet_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, usr_out;
  logic       mem_we;
  logic [7:0] usr_in = '0;
  logic       ld_en = 1'b0;
  logic [7:0] ld_a = '0, ld_d = '0;
  logic [7:0] mem [256];
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  octet_core u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .usr_in(usr_in), .usr_out(usr_out)
  );

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wipe();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      ld_en = 1'b1; ld_a = 8'(i); ld_d = 8'h00;
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    ld_en = 1'b1; ld_a = a; ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run(input int n);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    wipe();
    poke(8'h00, 8'hC0); poke(8'h01, 8'hE0);
    usr_in = 8'h5C;
    run(60);
    check("R9 pre-reset out", usr_out, 8'h5C);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 out cleared", usr_out, 8'h00);
    check("R2 no write", {7'd0, mem_we}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R2 fetch at 0", mem_addr, 8'h00);
  endtask

  task automatic t_example();
    wipe();
    poke(0, 8'h00); poke(1, 8'hC0); poke(2, 8'h68); poke(3, 8'hC0);
    poke(4, 8'h21); poke(5, 8'hE0); poke(6, 8'h44); poke(7, 8'h07);
    usr_in = 8'h17;
    run(200);
    check("R4 R3 sum loop", usr_out, 8'h2E);
    usr_in = 8'h90;
    run(200);
    check("R4 wrap mod 256", usr_out, 8'h20);
  endtask

  task automatic t_ip_wrap();
    wipe();
    poke(0, 8'hC0); poke(1, 8'hE0);
    usr_in = 8'h21;
    run(100);
    check("R1 first pass", usr_out, 8'h21);
    usr_in = 8'h42;
    run(1000);
    check("R1 no early rerun", usr_out, 8'h21);
    run(1000);
    check("R1 ip wraps to 0", usr_out, 8'h42);
  endtask

  task automatic t_flag_reset();
    wipe();
    poke(0, 8'h0F); poke(1, 8'hC0); poke(2, 8'hE0);
    usr_in = 8'h55;
    run(300);
    check("R10 flags clear after reset", usr_out, 8'h55);
  endtask

  task automatic t_jump(input logic [7:0] mask, input logic [7:0] val,
                        input logic [7:0] exp, input string tag);
    wipe();
    poke(0, 8'hC0); poke(1, mask); poke(2, 8'h64); poke(6, 8'hE0);
    usr_in = val;
    run(150);
    check(tag, usr_out, exp);
  endtask

  task automatic t_alu();
    wipe();
    poke(0, 8'hC0); poke(1, 8'h27); poke(2, 8'h68); poke(3, 8'hC0);
    poke(4, 8'h41); poke(5, 8'hE0);
    usr_in = 8'h5A;
    run(200);
    check("R5 R6 R7 and reg, add imm, move", usr_out, 8'h58);
    wipe();
    poke(0, 8'hC0); poke(1, 8'h6C); poke(2, 8'h75); poke(3, 8'h2A); poke(4, 8'hE0);
    usr_in = 8'h3C;
    run(200);
    check("R4 add dest R0", usr_out, 8'hFF);
    wipe();
    poke(0, 8'hC0); poke(1, 8'h6C); poke(2, 8'h75); poke(3, 8'h57); poke(4, 8'hE0);
    usr_in = 8'h3E;
    run(200);
    check("R5 R6 and imm dest R0", usr_out, 8'h02);
  endtask

  task automatic t_mem();
    wipe();
    poke(0, 8'hC8); poke(1, 8'h75); poke(2, 8'hB1); poke(3, 8'h99); poke(4, 8'hF8);
    poke(8'h80, 8'h11);
    usr_in = 8'h80;
    run(200);
    check("R8 store then load", usr_out, 8'h7F);
    check("R8 store data", mem[8'h80], 8'h7F);
    wipe();
    poke(0, 8'hC8); poke(1, 8'h99); poke(2, 8'hF8); poke(8'h90, 8'hA5);
    usr_in = 8'h90;
    run(150);
    check("R8 load preset", usr_out, 8'hA5);
    check("R8 no stray write", mem[8'h91], 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_example();
    t_flag_reset();
    t_jump(8'h01, 8'h06, 8'h06, "R3 taken on p");
    t_jump(8'h01, 8'hF0, 8'h0F, "R3 R10 not taken on n");
    t_jump(8'h01, 8'h00, 8'hFF, "R3 R10 not taken on z");
    t_jump(8'h06, 8'h06, 8'hF9, "R3 mask nz vs p");
    t_alu();
    t_mem();
    t_ip_wrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule